// File: doc/BRIEF.md
# Dual-Field Montgomery Inverse, First Phase

This block runs the first phase of Montgomery inversion on a full-width operand. It takes a modulus `p` and an operand `a` and returns `s` together with an iteration count `k`, where `a * s` is congruent to `2^k` modulo `p`. A mode pin picks the arithmetic. In prime mode, add and subtract use two's complement. In binary mode, they become carry-free XOR over GF(2) polynomials, and the result satisfies `a(x) s(x) = x^k mod p(x)`. A later multiplication or correction stage turns `(s, k)` into whichever Montgomery-domain inverse it needs.

The engine holds four working registers and runs one loop iteration per clock. It picks a branch by comparing the bit lengths of `u` and `v`, not their magnitudes. In prime mode this can make `u` negative, and the next iteration repairs the sign. A halving step can drop up to three trailing zeros in one cycle. Two correction cycles then bring `s` into `[0, p)` in prime mode, or below degree N in binary mode.

Requests use a valid/ready pair. `req_ready` is high only while the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While the engine is busy, `req_valid` is ignored and the caller must hold or retry. There is no back-pressure on the result side. `done` pulses for one cycle, and `inv_out`/`cnt_out` keep their values until the next result is written.

Top module: `minv_phase1`

## Requirements
- R1: `req_ready` is high exactly when idle. A request is taken only on an edge with `req_valid` and `req_ready` both high, after which `req_ready` drops. `req_valid` raised while busy is ignored: no extra result appears, and the running result is unaffected.
- R2: With `mode` = 0 (prime), `p` is an odd prime below 2^N with bit N clear, and `0 < a < p`. The result satisfies `inv_out < p` and `a * inv_out mod p = 2^cnt_out mod p`. This holds also when `u` passes through negative values during the loop.
- R3: With `mode` = 1 (binary), `p` is an irreducible polynomial of degree exactly N, with bit i holding the coefficient of x^i, and `a` is nonzero. The result satisfies `a(x) * inv_out(x) mod p(x) = x^cnt_out mod p(x)`, with degree below N.
- R4: In prime mode, `L <= cnt_out <= 2L`, where L is the bit length of `p`. In binary mode, `N+1 <= cnt_out <= deg(a)+N+1`.
- R5: `done` is high for a single cycle. It rises no more than `cnt_out + 3` clock edges after the accepting edge.
- R6: A halving step removes up to three trailing zeros in one cycle and adds that many to `k`. With `t` trailing zeros in `a` and `t >= 2`, the latency is at most `cnt_out + 3 - (min(t,3) - 1)` edges.
- R7: `inv_out` and `cnt_out` change only on the edge that raises `done`. Between results they hold, whatever the inputs do.
- R8: After reset, `req_ready` = 1, `done` = 0, `inv_out` = 0 and `cnt_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe for mode, modulus and operand |
| req_ready | output | 1 | Engine idle; a request is accepted this cycle if valid |
| mode | input | 1 | 0 = prime field, 1 = binary field |
| mod_in | input | N+1 | Modulus `p` (bit N set only in binary mode) |
| opd_in | input | N | Operand `a` |
| done | output | 1 | One-cycle result strobe |
| inv_out | output | N | Result `s` |
| cnt_out | output | clog2(2N+3) | Iteration count `k` |

## Verification
A wrong branch choice, sign repair or shift amount corrupts the `(s, k)` pair. The congruence `a*s = 2^k` then fails on the `done` strobe of that same request, because the bench checks the congruence rather than one fixed value. A shifter that takes too few or too many zeros shows up in two ways: `k` leaves its theoretical bounds, or the latency no longer fits the `k`-derived window. A broken correction stage gives an out-of-range `inv_out` at once, and a faulty handshake gives an orphan or missing `done`.

// File: rtl/minv_pkg.sv
`timescale 1ns/1ps
package minv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_FIX1 = 2'd2,
    ST_FIX2 = 2'd3
  } minv_state_e;

  typedef enum logic {
    FLD_PRIME = 1'b0,
    FLD_BIN   = 1'b1
  } field_e;
endpackage

// File: rtl/minv_bitlen.sv
`timescale 1ns/1ps
// Position of the highest set bit plus one; zero for a zero input.
module minv_bitlen #(
  parameter int W  = 18,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [LW-1:0] len
);
  always_comb begin
    len = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) len = LW'(i + 1);
    end
  end
endmodule

// File: rtl/minv_step.sv
`timescale 1ns/1ps
// One loop iteration of the unified inversion engine (combinational).
module minv_step
  import minv_pkg::*;
#(
  parameter int N     = 16,
  parameter int MAXSH = 3,
  localparam int UW   = N + 2,
  localparam int SW   = N + 3,
  localparam int LW   = $clog2(UW + 1)
) (
  input  field_e                fld,
  input  logic signed [UW-1:0]  u_i,
  input  logic signed [UW-1:0]  v_i,
  input  logic signed [SW-1:0]  r_i,
  input  logic signed [SW-1:0]  s_i,
  input  logic        [LW-1:0]  ulen,
  input  logic        [LW-1:0]  vlen,
  output logic signed [UW-1:0]  u_o,
  output logic signed [UW-1:0]  v_o,
  output logic signed [SW-1:0]  r_o,
  output logic signed [SW-1:0]  s_o,
  output logic        [1:0]     adv_o,
  output logic                  fin_o
);
  localparam logic [1:0] SHCAP = 2'(MAXSH);

  // trailing zeros of an even value, limited to three and to MAXSH
  function automatic logic [1:0] zero_run(input logic [2:0] low);
    logic [1:0] n;
    if (low[1])      n = 2'd1;
    else if (low[2]) n = 2'd2;
    else             n = 2'd3;
    return (n > SHCAP) ? SHCAP : n;
  endfunction

  logic                 bin;
  logic                 uneg;
  logic signed [UW-1:0] u_less_v;
  logic signed [UW-1:0] v_less_u;
  logic signed [UW-1:0] v_with_u;
  logic signed [SW-1:0] rs_sum;
  logic signed [SW-1:0] s_less_r;
  logic        [1:0]    sh;

  assign bin      = (fld == FLD_BIN);
  assign uneg     = !bin && u_i[UW-1];
  assign u_less_v = bin ? (u_i ^ v_i) : (u_i - v_i);
  assign v_less_u = bin ? (v_i ^ u_i) : (v_i - u_i);
  assign v_with_u = v_i + u_i;
  assign rs_sum   = bin ? (r_i ^ s_i) : (r_i + s_i);
  assign s_less_r = s_i - r_i;

  always_comb begin
    u_o   = u_i;
    v_o   = v_i;
    r_o   = r_i;
    s_o   = s_i;
    adv_o = 2'd1;
    fin_o = 1'b0;
    sh    = 2'd1;
    if (!uneg) begin
      if (ulen == '0) begin
        fin_o = 1'b1;
        adv_o = 2'd0;
      end else if (!u_i[0]) begin
        sh    = zero_run(u_i[2:0]);
        u_o   = u_i >>> sh;
        s_o   = s_i <<< sh;
        adv_o = sh;
      end else if (!v_i[0]) begin
        sh    = zero_run(v_i[2:0]);
        v_o   = v_i >>> sh;
        r_o   = r_i <<< sh;
        adv_o = sh;
      end else if (ulen >= vlen) begin
        u_o = u_less_v >>> 1;
        r_o = rs_sum;
        s_o = s_i <<< 1;
      end else begin
        v_o = v_less_u >>> 1;
        s_o = rs_sum;
        r_o = r_i <<< 1;
      end
    end else if (!u_i[0]) begin
      u_o = (-u_i) >>> 1;
      s_o = s_i <<< 1;
      r_o = -r_i;
    end else begin
      v_o = v_with_u >>> 1;
      u_o = -u_i;
      s_o = s_less_r;
      r_o = -(r_i <<< 1);
    end
  end
endmodule

// File: rtl/minv_fixup.sv
`timescale 1ns/1ps
// Range correction. STAGE 1 repairs a negative s (prime) or bit N+1 (binary);
// STAGE 2 removes excess multiples of p (prime) or bit N (binary).
module minv_fixup
  import minv_pkg::*;
#(
  parameter int N     = 16,
  parameter int STAGE = 1,
  localparam int SW   = N + 3
) (
  input  field_e               fld,
  input  logic signed [SW-1:0] s_i,
  input  logic signed [SW-1:0] p_i,
  output logic signed [SW-1:0] s_o
);
  logic signed [SW-1:0] p_dbl;
  assign p_dbl = p_i <<< 1;

  generate
    if (STAGE == 1) begin : g_lift
      logic signed [SW-1:0] plus1;
      logic signed [SW-1:0] plus2;
      assign plus1 = s_i + p_i;
      assign plus2 = s_i + p_dbl;
      always_comb begin
        if (fld == FLD_BIN)  s_o = s_i[N+1] ? (s_i ^ p_dbl) : s_i;
        else if (!s_i[SW-1]) s_o = s_i;
        else                 s_o = plus1[SW-1] ? plus2 : plus1;
      end
    end else begin : g_trim
      logic signed [SW-1:0] less1;
      logic signed [SW-1:0] less2;
      assign less1 = s_i - p_i;
      assign less2 = s_i - p_dbl;
      always_comb begin
        if (fld == FLD_BIN)    s_o = s_i[N] ? (s_i ^ p_i) : s_i;
        else if (!less2[SW-1]) s_o = less2;
        else if (!less1[SW-1]) s_o = less1;
        else                   s_o = s_i;
      end
    end
  endgenerate
endmodule

// File: rtl/minv_phase1.sv
`timescale 1ns/1ps
module minv_phase1
  import minv_pkg::*;
#(
  parameter int N     = 16,
  parameter int MAXSH = 3,
  localparam int KW   = $clog2(2 * N + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          mode,
  input  logic [N:0]    mod_in,
  input  logic [N-1:0]  opd_in,
  output logic          done,
  output logic [N-1:0]  inv_out,
  output logic [KW-1:0] cnt_out
);
  localparam int PW = N + 1;
  localparam int UW = N + 2;
  localparam int SW = N + 3;
  localparam int LW = $clog2(UW + 1);

  minv_state_e          state_q;
  field_e               mode_q;
  logic        [PW-1:0] p_q;
  logic signed [UW-1:0] u_q, v_q;
  logic signed [SW-1:0] r_q, s_q;
  logic        [KW-1:0] k_q;

  logic        [LW-1:0] ulen, vlen;
  logic signed [UW-1:0] u_nx, v_nx;
  logic signed [SW-1:0] r_nx, s_nx;
  logic        [1:0]    adv;
  logic                 fin;
  logic signed [SW-1:0] p_ext;
  logic signed [SW-1:0] s_fix1, s_fix2;

  assign req_ready = (state_q == ST_IDLE);
  assign p_ext     = {{(SW-PW){1'b0}}, p_q};

  minv_bitlen #(.W(UW), .LW(LW)) u_len_u (.val(u_q), .len(ulen));
  minv_bitlen #(.W(UW), .LW(LW)) u_len_v (.val(v_q), .len(vlen));

  minv_step #(.N(N), .MAXSH(MAXSH)) u_step (
    .fld(mode_q), .u_i(u_q), .v_i(v_q), .r_i(r_q), .s_i(s_q),
    .ulen(ulen), .vlen(vlen),
    .u_o(u_nx), .v_o(v_nx), .r_o(r_nx), .s_o(s_nx),
    .adv_o(adv), .fin_o(fin)
  );

  minv_fixup #(.N(N), .STAGE(1)) u_fix1 (
    .fld(mode_q), .s_i(s_q), .p_i(p_ext), .s_o(s_fix1)
  );
  minv_fixup #(.N(N), .STAGE(2)) u_fix2 (
    .fld(mode_q), .s_i(s_q), .p_i(p_ext), .s_o(s_fix2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= FLD_PRIME;
      p_q     <= '0;
      u_q     <= '0;
      v_q     <= '0;
      r_q     <= '0;
      s_q     <= '0;
      k_q     <= '0;
      done    <= 1'b0;
      inv_out <= '0;
      cnt_out <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            mode_q  <= field_e'(mode);
            p_q     <= mod_in;
            u_q     <= {1'b0, mod_in};
            v_q     <= {2'b00, opd_in};
            r_q     <= '0;
            s_q     <= SW'(1);
            k_q     <= '0;
            state_q <= ST_LOOP;
          end
        end
        ST_LOOP: begin
          if (fin) begin
            state_q <= ST_FIX1;
          end else begin
            u_q <= u_nx;
            v_q <= v_nx;
            r_q <= r_nx;
            s_q <= s_nx;
            k_q <= k_q + KW'(adv);
          end
        end
        ST_FIX1: begin
          s_q     <= s_fix1;
          state_q <= ST_FIX2;
        end
        ST_FIX2: begin
          inv_out <= s_fix2[N-1:0];
          cnt_out <= k_q;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/minv_phase1_chk.sv
`timescale 1ns/1ps
module minv_phase1_chk
  import minv_pkg::*;
#(
  parameter int N   = 16,
  localparam int KW = $clog2(2 * N + 3)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                done,
  input logic [N-1:0]        inv_out,
  input logic [KW-1:0]       cnt_out,
  input minv_state_e         state_q,
  input field_e              mode_q,
  input logic [N:0]          p_q,
  input logic signed [N+1:0] u_q,
  input logic signed [N+1:0] v_q,
  input logic [KW-1:0]       k_q
);
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R1

  AST_PRIME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q == FLD_PRIME) |-> ({1'b0, inv_out} < p_q)); // R2

  AST_V_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP) |-> (v_q != '0)); // R2

  AST_BIN_U_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP && mode_q == FLD_BIN) |-> !u_q[N+1]); // R3

  AST_K_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (k_q <= KW'(2 * N + 1))); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(inv_out) && $stable(cnt_out))); // R7
endmodule

bind minv_phase1 minv_phase1_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .inv_out(inv_out), .cnt_out(cnt_out), .state_q(state_q),
  .mode_q(mode_q), .p_q(p_q), .u_q(u_q), .v_q(v_q), .k_q(k_q)
);

// File: tb/minv_phase1_bench.sv
`timescale 1ns/1ps
module minv_phase1_bench;
  localparam int N  = 16;
  localparam int KW = $clog2(2 * N + 3);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          mode = 1'b0;
  logic [N:0]    mod_in = '0;
  logic [N-1:0]  opd_in = '0;
  logic          req_ready, done;
  logic [N-1:0]  inv_out;
  logic [KW-1:0] cnt_out;

  minv_phase1 #(.N(N)) u_minv_phase1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mode(mode), .mod_in(mod_in), .opd_in(opd_in), .done(done),
    .inv_out(inv_out), .cnt_out(cnt_out)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    bit     md;
    longint p;
    longint a;
    int     acc;
  } item_t;
  item_t sb[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint bitlen(input longint x);
    longint n = 0;
    while (x != 0) begin n++; x = x >> 1; end
    return n;
  endfunction

  function automatic longint pow2mod(input longint k, input longint p);
    longint r = 1 % p;
    for (longint i = 0; i < k; i++) r = (r * 2) % p;
    return r;
  endfunction

  function automatic longint gmul(input longint a, input longint b, input longint p);
    longint res = 0;
    longint aa = a;
    for (int i = 0; i < N; i++) begin
      if (b[i]) res = res ^ aa;
      aa = aa << 1;
      if (aa[N]) aa = aa ^ p;
    end
    return res;
  endfunction

  function automatic longint xpow(input longint k, input longint p);
    longint r = 1;
    for (longint i = 0; i < k; i++) begin
      r = r << 1;
      if (r[N]) r = r ^ p;
    end
    return r;
  endfunction

  function automatic longint tzeros(input longint a);
    longint t = 0;
    while (t < 3 && a[t] == 1'b0) t++;
    return t;
  endfunction

  // driver: present a request, wait for acceptance, record the expectation
  task automatic issue(input bit md, input longint p, input longint a);
    @(negedge clk);
    req_valid = 1'b1;
    mode      = md;
    mod_in    = (N+1)'(p);
    opd_in    = N'(a);
    while (!req_ready) @(negedge clk);
    sb.push_back('{md, p, a, cyc + 1});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor/scoreboard
  task automatic check_item();
    item_t  it;
    longint s, k, lat, L, sav;
    if (sb.size() == 0) begin
      chk(1'b0, "R1 result without request", 1, 0);
      return;
    end
    it  = sb.pop_front();
    s   = longint'(inv_out);
    k   = longint'(cnt_out);
    lat = longint'(cyc - it.acc);
    if (!it.md) begin
      chk(s < it.p, "R2 range", s, it.p - 1);
      chk(((it.a * s) % it.p) == pow2mod(k, it.p), "R2 congruence",
          (it.a * s) % it.p, pow2mod(k, it.p));
      L = bitlen(it.p);
      chk(k >= L && k <= 2 * L, "R4 prime k bounds", k, L);
    end else begin
      chk(gmul(it.a, s, it.p) == xpow(k, it.p), "R3 congruence",
          gmul(it.a, s, it.p), xpow(k, it.p));
      chk(k >= N + 1 && k <= bitlen(it.a) + N, "R4 binary k bounds", k, N + 1);
    end
    chk(lat <= k + 3, "R5 latency", lat, k + 3);
    if (tzeros(it.a) >= 2) begin
      sav = tzeros(it.a) - 1;
      chk(lat <= k + 3 - sav, "R6 multibit shift latency", lat, k + 3 - sav);
    end
  endtask

  initial begin
    bit prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done) begin
        if (prev) chk(1'b0, "R5 done longer than one cycle", 1, 0);
        check_item();
      end
      prev = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0]  hold_s;
    logic [KW-1:0] hold_k;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R8 reset ready", req_ready, 1);
    chk(done == 1'b0, "R8 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
    chk(done == 1'b0, "R8 done after reset", done, 0);
    chk(inv_out == '0, "R8 inv_out after reset", inv_out, 0);
    chk(cnt_out == '0, "R8 cnt_out after reset", cnt_out, 0);

    // prime field, small and full-width moduli (R2, R4)
    issue(0, 7, 3);
    issue(0, 7, 5);
    issue(0, 3, 1);
    issue(0, 3, 2);
    for (int a = 1; a < 13; a++) issue(0, 13, a);
    for (int a = 1; a < 251; a += 7) issue(0, 251, a);
    issue(0, 65521, 1);
    issue(0, 65521, 65520);
    issue(0, 65521, 12345);
    issue(0, 65521, 40000);
    // trailing zeros in a exercise the multibit shifter (R6)
    issue(0, 65521, 8);
    issue(0, 32749, 1024);
    issue(0, 32749, 4);

    // R1: requests raised while busy are ignored
    issue(0, 65521, 777);
    req_valid = 1'b1;
    mode      = 1'b1;
    mod_in    = '1;
    opd_in    = 5;
    chk(req_ready == 1'b0, "R1 busy ready low", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b0, "R1 busy ready still low", req_ready, 0);
    req_valid = 1'b0;
    drain();

    // binary field, two irreducible degree-16 polynomials (R3, R4)
    issue(1, 64'h1002D, 1);
    issue(1, 64'h1002D, 2);
    issue(1, 64'h1002D, 8);
    issue(1, 64'h1002D, 64'hFFFF);
    issue(1, 64'h1002D, 64'h8000);
    issue(1, 64'h16801, 64'h1234);
    for (int a = 1; a <= 20; a++) issue(1, 64'h16801, a);
    issue(0, 65521, 3);
    drain();

    // R7: outputs hold while idle and inputs wander
    @(negedge clk);
    hold_s = inv_out;
    hold_k = cnt_out;
    for (int i = 0; i < 6; i++) begin
      mode   = ~mode;
      mod_in = mod_in + 3;
      opd_in = opd_in ^ 16'h5A5A;
      @(negedge clk);
    end
    chk(inv_out == hold_s, "R7 inv_out held", inv_out, hold_s);
    chk(cnt_out == hold_k, "R7 cnt_out held", cnt_out, hold_k);
    chk(sb.size() == 0, "R1 no pending results", sb.size(), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule